// File: doc/BRIEF.md
# Hierarchical Lookahead Adder, 16 Bits

This block adds two 16-bit operands and a carry input in a single combinational pass. The operands are split into four slices of four bits. Each slice forms a generate term (a AND b) and a propagate term (a OR b) for every bit. From these, each slice computes all of its internal carries in expanded sum-of-products form, and it also forms one slice-level generate and one slice-level propagate.

A second lookahead stage uses the same equations on the four slice-level pairs. It produces the carry into slices 1 to 3 and the final carry out, so no carry ripples from one slice to the next. The carry out is ready after roughly five gate levels, where a plain ripple chain over 16 bits needs about 32.

The block also drives the overall generate and propagate of all 16 bits. A third lookahead level can therefore stack four copies into a 64-bit adder. The block has no clock and no state.

Top module: `cla16_adder`

## Requirements
- R1: `sum` equals (`op_a` + `op_b` + `carry_in`) modulo 2^16 for every input combination.
- R2: `carry_out` equals bit 16 of the 17-bit true sum `op_a` + `op_b` + `carry_in`.
- R3: `blk_prop` is 1 exactly when, at every one of the 16 bit positions, at least one of `op_a`, `op_b` has a 1 (propagate is the OR of the two bits, so it is also 1 where both bits are 1).
- R4: `blk_gen` is 1 exactly when `op_a` + `op_b` with no carry in is at least 2^16.
- R5: `carry_out` equals `blk_gen` OR (`blk_prop` AND `carry_in`), so the block can feed a higher lookahead level.
- R6: Within every lookahead unit, each carry it forms obeys c(i+1) = g(i) OR (p(i) AND c(i)) with respect to the carry below it.
- R7: The carry out of each 4-bit slice, formed inside the slice, agrees with the carry that the second-level unit hands to the next slice (or with `carry_out` for the top slice).
- R8: A carry entering at bit 0 reaches `carry_out` when every bit propagates and none generates: `op_a` + `op_b` = 0xFFFF with `carry_in` = 1 gives `sum` = 0 and `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |
| blk_gen | output | 1 | Generate over all 16 bits |
| blk_prop | output | 1 | Propagate over all 16 bits |

## Verification
The immediate assertions take for granted that every input bit is a defined 0 or 1 and that the inputs stay still long enough for the combinational cone to settle before the check is evaluated. The stimulus changes the inputs only just after a rising clock edge and compares the outputs half a period later. Every vector is fully two-state, including the exhaustive per-slice sweeps and the random vectors.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Slice width and slice count of the default build.
  localparam int SLICE_BITS = 4;
  localparam int SLICE_CNT  = 4;

  // One-bit carry generate term.
  function automatic logic bit_gen(input logic a, input logic b);
    return a & b;
  endfunction

  // One-bit carry propagate term (inclusive form).
  function automatic logic bit_prop(input logic a, input logic b);
    return a | b;
  endfunction

  // One-bit sum from operands and the carry entering the bit.
  function automatic logic bit_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction
endpackage

// File: rtl/cla_lookahead.sv
// Flat lookahead unit: every carry is formed as a sum of products
// directly from the generate/propagate vector and the incoming carry.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin,
  output logic [N:0]   carry,
  output logic         grp_gen,
  output logic         grp_prop
);
  always_comb begin
    carry[0] = cin;
    for (int j = 1; j <= N; j++) begin
      logic term;
      logic allp;
      term = 1'b0;
      for (int k = 0; k < j; k++) begin
        logic prod;
        prod = gen_i[k];
        for (int m = k + 1; m < j; m++) prod = prod & prop_i[m];
        term = term | prod;
      end
      allp = 1'b1;
      for (int m = 0; m < j; m++) allp = allp & prop_i[m];
      carry[j] = term | (allp & cin);
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic prod;
      prod = gen_i[k];
      for (int m = k + 1; m < N; m++) prod = prod & prop_i[m];
      acc = acc | prod;
    end
    grp_gen = acc;
  end

  always_comb begin
    logic allp;
    allp = 1'b1;
    for (int m = 0; m < N; m++) allp = allp & prop_i[m];
    grp_prop = allp;
  end

  // R6: flat products must agree with the bit-serial recurrence.
  always_comb begin
    for (int j = 0; j < N; j++) begin
      a_r6_carry_recurrence: assert (carry[j+1] == (gen_i[j] | (prop_i[j] & carry[j])))
        else $error("R6 carry %0d breaks recurrence", j + 1);
    end
  end

  // R5: the unit's own carry out is explained by its group pair.
  always_comb begin
    a_r5_group_pair: assert (carry[N] == (grp_gen | (grp_prop & cin)))
      else $error("R5 carry out disagrees with group generate/propagate");
  end
endmodule

// File: rtl/cla_slice.sv
// One slice of the adder: bit terms, internal lookahead, sum bits.
module cla_slice
  import cla_pkg::*;
#(
  parameter int W = SLICE_BITS
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout_local,
  output logic         s_gen,
  output logic         s_prop
);
  logic [W-1:0] g;
  logic [W-1:0] p;
  logic [W:0]   c;

  always_comb begin
    for (int i = 0; i < W; i++) begin
      g[i] = bit_gen(a[i], b[i]);
      p[i] = bit_prop(a[i], b[i]);
    end
  end

  cla_lookahead #(.N(W)) u_la (
    .gen_i   (g),
    .prop_i  (p),
    .cin     (cin),
    .carry   (c),
    .grp_gen (s_gen),
    .grp_prop(s_prop)
  );

  always_comb begin
    for (int i = 0; i < W; i++) s[i] = bit_sum(a[i], b[i], c[i]);
  end

  assign cout_local = c[W];

  // R1: each slice is a correct W-bit adder in its own right.
  always_comb begin
    a_r1_slice_sum: assert ({cout_local, s} == ({1'b0, a} + {1'b0, b} + (W+1)'(cin)))
      else $error("R1 slice sum wrong");
  end
endmodule

// File: rtl/cla16_adder.sv
module cla16_adder
  import cla_pkg::*;
#(
  parameter int SW = SLICE_BITS,
  parameter int NS = SLICE_CNT
) (
  input  logic [SW*NS-1:0] op_a,
  input  logic [SW*NS-1:0] op_b,
  input  logic             carry_in,
  output logic [SW*NS-1:0] sum,
  output logic             carry_out,
  output logic             blk_gen,
  output logic             blk_prop
);
  localparam int W = SW * NS;

  logic [NS-1:0] sl_gen;
  logic [NS-1:0] sl_prop;
  logic [NS-1:0] sl_cout;
  logic [NS:0]   sl_cin;

  for (genvar k = 0; k < NS; k++) begin : g_slice
    cla_slice #(.W(SW)) u_slice (
      .a         (op_a[k*SW +: SW]),
      .b         (op_b[k*SW +: SW]),
      .cin       (sl_cin[k]),
      .s         (sum[k*SW +: SW]),
      .cout_local(sl_cout[k]),
      .s_gen     (sl_gen[k]),
      .s_prop    (sl_prop[k])
    );
  end

  cla_lookahead #(.N(NS)) u_top_la (
    .gen_i   (sl_gen),
    .prop_i  (sl_prop),
    .cin     (carry_in),
    .carry   (sl_cin),
    .grp_gen (blk_gen),
    .grp_prop(blk_prop)
  );

  assign carry_out = sl_cin[NS];

  // R7: slice-local carry out agrees with the second-level carry above it.
  always_comb begin
    for (int k = 0; k < NS; k++) begin
      a_r7_slice_carry_agree: assert (sl_cout[k] == sl_cin[k+1])
        else $error("R7 slice %0d carry mismatch", k);
    end
  end

  // R1/R2: whole-width arithmetic check.
  always_comb begin
    a_r2_full_sum: assert ({carry_out, sum} == ({1'b0, op_a} + {1'b0, op_b} + (W+1)'(carry_in)))
      else $error("R1/R2 full sum wrong");
  end

  // R4: overall generate equals the carry of the add with zero carry in.
  always_comb begin
    logic [W:0] t;
    t = {1'b0, op_a} + {1'b0, op_b};
    a_r4_block_gen: assert (blk_gen == t[W])
      else $error("R4 block generate wrong");
  end
endmodule

// File: tb/cla16_adder_test.sv
module cla16_adder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] op_a = '0;
  logic [15:0] op_b = '0;
  logic        carry_in = 1'b0;
  logic [15:0] sum;
  logic        carry_out, blk_gen, blk_prop;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  cla16_adder uut (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out), .blk_gen(blk_gen), .blk_prop(blk_prop)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (a=%h b=%h cin=%0d)",
               req, act, exp, op_a, op_b, carry_in);
    end
  endtask

  // Drive after a rising edge, compare at the falling edge.
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    longint total, nocarry;
    int allprop;
    @(posedge clk);
    op_a = a; op_b = b; carry_in = c;
    @(negedge clk);
    total   = longint'(a) + longint'(b) + longint'(c);
    nocarry = longint'(a) + longint'(b);
    allprop = 1;
    for (int i = 0; i < 16; i++) if (a[i] == 1'b0 && b[i] == 1'b0) allprop = 0;
    chk("R1 sum", sum, total % 65536);
    chk("R2 carry_out", carry_out, total / 65536);
    chk("R3 blk_prop", blk_prop, allprop);
    chk("R4 blk_gen", blk_gen, (nocarry >= 65536) ? 1 : 0);
    chk("R5 cascade", carry_out, (blk_gen | (blk_prop & c)));
  endtask

  initial begin
    // Zero inputs first.
    apply(16'h0000, 16'h0000, 1'b0);
    // R8: carry entering at bit 0 runs through all 16 bits.
    apply(16'hFFFF, 16'h0000, 1'b1);
    chk("R8 full chain sum", sum, 0);
    chk("R8 full chain cout", carry_out, 1);
    apply(16'hAAAA, 16'h5555, 1'b1);
    chk("R8 alternating chain", {carry_out, sum}, 17'h10000);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'h0FFF, 16'h0001, 1'b0);
    // R7: exhaustive sweep of each slice, other slices zero or propagating.
    for (int k = 0; k < 4; k++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++) begin
            logic [15:0] ea, eb;
            ea = 16'(x) << (4*k);
            eb = 16'(y) << (4*k);
            if (c == 1) ea = ea | ~(16'hF << (4*k)) & 16'hFFFF & ~eb;
            apply(ea, eb, 1'(c));
          end
    // R6 / R1: random vectors.
    for (int n = 0; n < 1500; n++)
      apply(16'($urandom), 16'($urandom), 1'($urandom));
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule